// File: doc/BRIEF.md
# Half-Warp Access Coalescer

This block gathers the memory requests of a sixteen-lane group and turns them into the smallest set of naturally aligned transactions its rules allow. Each lane gives an active flag and a byte address. The whole group shares one element-size code and one strict-ordering flag. The group is loaded in one handshake. The block then emits transactions one at a time over a valid/ready link. Each transaction carries an aligned base, a length of 32, 64 or 128 bytes, and a mask of the lanes it serves.

Each round starts from the lowest-numbered lane still waiting. That lane's address selects a segment, and the segment size follows the element size. Every waiting lane whose address falls in that segment joins the round. The segment is then halved as long as all joined lanes sit in a single half. In strict mode the group is merged only when every active lane k addresses word k of one aligned segment. If any lane breaks that rule, each active lane is sent alone.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset, txnValid and done are low and reqReady is high.
- R2: Each transaction serves the lowest-numbered lane still waiting, so transactions come out in ascending order of their lowest lane.
- R3: The size code selects the element and segment size: 0 gives 1 byte and 32 bytes, 1 gives 2 bytes and 64 bytes, 2 gives 4 bytes and 128 bytes, 3 gives 8 bytes and 128 bytes. Addresses are aligned to the element size.
- R4: Every waiting lane whose address lies in the leading lane's segment is served by the same transaction.
- R5: A 128-byte segment whose served lanes all fall in one 64-byte half becomes a 64-byte transaction at that half. The same rule then shrinks a 64-byte segment to 32 bytes.
- R6: Every transaction base is aligned to its length, the length is 32, 64 or 128, and every lane in the mask addresses a byte inside [base, base+length).
- R7: The masks of one group together equal the active set, and no lane appears in two masks.
- R8: In strict mode, if every active lane k addresses byte base + k × element size, where base is the segment of the lowest active lane, then the group is served as in non-strict mode.
- R9: In strict mode, if any active lane breaks the R8 rule, each active lane gets its own transaction, in ascending lane order.
- R10: While txnValid is high and txnReady is low, the transaction's base, length and mask stay unchanged.
- R11: done pulses for one cycle, in the cycle after the last transaction of a group is accepted. reqReady is high only while no group is in progress, and a request made while busy is not taken.
- R12: A group with no active lanes produces no transaction, and done pulses in the cycle after the group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request group is offered |
| reqReady | output | 1 | The block is idle and takes the group |
| reqActive | input | LANES | Active flag per lane |
| reqAddr | input | LANES*AW | Byte address per lane; lane k in bits [k*AW +: AW] |
| reqSize | input | 2 | Element size code (R3) |
| reqStrict | input | 1 | Strict ordering mode |
| txnValid | output | 1 | A transaction is offered |
| txnReady | input | 1 | Downstream accepts the transaction |
| txnBase | output | AW | Aligned transaction base address |
| txnBytes | output | 8 | Transaction length in bytes |
| txnMask | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse at the end of a group |

## Verification
One cycle can carry both the done pulse of a group and the acceptance of the next group. The block is already idle when done is high, so a new request offered then is taken at once. Every scenario task drives its group at the same edge where the previous task has just checked done, which makes this overlap happen on every scenario boundary. The test then checks that done was seen high and that the new group's transactions fully match the model. In another scenario, reqValid is held high with unrelated data while a group is still being drained with backpressure. There reqReady must stay low and the drained transactions must not change.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture a new group
    logic pop;    // current transaction accepted
  } hwcCtrl_t;

  // log2 of segment bytes for an element size code
  function automatic logic [2:0] segShiftOf(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd5;
      2'd1:    return 3'd6;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/hwc_datapath.sv
module hwc_datapath
  import hwc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  hwcCtrl_t           ctrl,
  input  logic [LANES-1:0]   inActive,
  input  logic [LANES*AW-1:0] inAddr,
  input  logic [1:0]         inSize,
  input  logic               inStrict,
  output logic [AW-1:0]      txnBase,
  output logic [7:0]         txnBytes,
  output logic [LANES-1:0]   txnMask,
  output logic               lastTxn
);
  localparam int IDXW = $clog2(LANES);

  logic [AW-1:0]    addrQ [LANES];
  logic [LANES-1:0] pendQ, actQ;
  logic [1:0]       sizeQ;
  logic             strictQ;

  // group storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      actQ    <= '0;
      sizeQ   <= '0;
      strictQ <= 1'b0;
    end else if (ctrl.load) begin
      pendQ   <= inActive;
      actQ    <= inActive;
      sizeQ   <= inSize;
      strictQ <= inStrict;
    end else if (ctrl.pop) begin
      pendQ   <= pendQ & ~txnMask;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      for (int k = 0; k < LANES; k++) addrQ[k] <= inAddr[k*AW +: AW];
    end
  end

  // lowest waiting lane and lowest active lane
  logic [IDXW-1:0] leadIdx, firstIdx;
  always_comb begin
    leadIdx  = '0;
    firstIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendQ[i]) leadIdx  = IDXW'(i);
      if (actQ[i])  firstIdx = IDXW'(i);
    end
  end

  logic [2:0]    segShift;
  logic [AW-1:0] alignMask, segBase, firstBase;
  assign segShift  = segShiftOf(sizeQ);
  assign alignMask = ~((AW'(1) << segShift) - AW'(1));
  assign segBase   = addrQ[leadIdx] & alignMask;
  assign firstBase = addrQ[firstIdx] & alignMask;

  logic [LANES-1:0] laneInSeg, laneWordOk, laneHi64, laneHi32;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneInSeg[k]  = (addrQ[k] & alignMask) == segBase;
    assign laneWordOk[k] = !actQ[k] ||
                           (addrQ[k] == firstBase + (AW'(k) << sizeQ));
    assign laneHi64[k]   = addrQ[k][6];
    assign laneHi32[k]   = addrQ[k][5];
  end

  logic             serialize;
  logic [LANES-1:0] leadOneHot, member;
  assign serialize  = strictQ && !(&laneWordOk);
  assign leadOneHot = LANES'(1) << leadIdx;
  assign member     = pendQ & (serialize ? leadOneHot : laneInSeg);

  // size reduction 128 -> 64 -> 32
  logic [2:0]    redShift;
  logic [AW-1:0] redBase;
  logic          hiAny64, loAny64, hiAny32, loAny32;
  always_comb begin
    redShift = segShift;
    redBase  = segBase;
    hiAny64  = |(member & laneHi64);
    loAny64  = |(member & ~laneHi64);
    hiAny32  = |(member & laneHi32);
    loAny32  = |(member & ~laneHi32);
    if (redShift == 3'd7 && !(hiAny64 && loAny64)) begin
      redShift = 3'd6;
      if (hiAny64) redBase[6] = 1'b1;
    end
    if (redShift == 3'd6 && !(hiAny32 && loAny32)) begin
      redShift = 3'd5;
      if (hiAny32) redBase[5] = 1'b1;
    end
  end

  assign txnBase  = redBase;
  assign txnBytes = 8'(1) << redShift;
  assign txnMask  = member;
  assign lastTxn  = (pendQ & ~member) == '0;
endmodule

// File: rtl/hwc_control.sv
module hwc_control
  import hwc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqEmpty,
  input  logic     txnReady,
  input  logic     lastTxn,
  output hwcCtrl_t ctrl,
  output logic     reqReady,
  output logic     txnValid,
  output logic     done
);
  logic busyQ, doneQ;
  logic accept, pop;

  assign accept    = reqValid && !busyQ;
  assign pop       = busyQ && txnReady;
  assign ctrl.load = accept;
  assign ctrl.pop  = pop;
  assign reqReady  = !busyQ;
  assign txnValid  = busyQ;
  assign done      = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= (accept && reqEmpty) || (pop && lastTxn);
      if (accept)              busyQ <= !reqEmpty;
      else if (pop && lastTxn) busyQ <= 1'b0;
    end
  end
endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer
  import hwc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [LANES-1:0]    reqActive,
  input  logic [LANES*AW-1:0] reqAddr,
  input  logic [1:0]          reqSize,
  input  logic                reqStrict,
  output logic                txnValid,
  input  logic                txnReady,
  output logic [AW-1:0]       txnBase,
  output logic [7:0]          txnBytes,
  output logic [LANES-1:0]    txnMask,
  output logic                done
);
  hwcCtrl_t ctrl;
  logic     lastTxn;

  hwc_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqEmpty(reqActive == '0), .txnReady(txnReady), .lastTxn(lastTxn),
    .ctrl(ctrl), .reqReady(reqReady), .txnValid(txnValid), .done(done)
  );

  hwc_datapath #(.LANES(LANES), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inActive(reqActive),
    .inAddr(reqAddr), .inSize(reqSize), .inStrict(reqStrict),
    .txnBase(txnBase), .txnBytes(txnBytes), .txnMask(txnMask),
    .lastTxn(lastTxn)
  );
endmodule

// File: rtl/hwc_coalescer_chk.sv
module hwc_coalescer_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [LANES-1:0] reqActive,
  input logic             txnValid,
  input logic             txnReady,
  input logic [AW-1:0]    txnBase,
  input logic [7:0]       txnBytes,
  input logic [LANES-1:0] txnMask,
  input logic             done
);
  // lanes still owed a transaction, tracked from the ports
  logic [LANES-1:0] remQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        remQ <= '0;
    else if (reqValid && reqReady)    remQ <= reqActive;
    else if (txnValid && txnReady)    remQ <= remQ & ~txnMask;
  end

  p_leader_r2: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnMask & remQ & (~remQ + LANES'(1))) != '0);

  p_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnBytes == 8'd32) || (txnBytes == 8'd64) || (txnBytes == 8'd128))
                 && ((txnBase & (AW'(txnBytes) - AW'(1))) == '0));

  p_mask_fresh_r7: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnMask != '0) && ((txnMask & ~remQ) == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && !txnReady |=> txnValid && $stable(txnMask)
                              && $stable(txnBase) && $stable(txnBytes));

  p_done_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && txnReady && ((remQ & ~txnMask) == '0) |=> done);

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !reqReady);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !txnValid);

  p_empty_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqActive == '0) |=> done && !txnValid);
endmodule

bind hwc_coalescer hwc_coalescer_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqActive(reqActive), .txnValid(txnValid), .txnReady(txnReady),
  .txnBase(txnBase), .txnBytes(txnBytes), .txnMask(txnMask), .done(done)
);

// File: tb/hwc_coalescer_bench.sv
`timescale 1ns/1ps
module hwc_coalescer_bench;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [LANES-1:0] reqActive = '0;
  logic [LANES*AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic reqStrict = 1'b0;
  logic txnValid, txnReady = 1'b0;
  logic [AW-1:0] txnBase;
  logic [7:0] txnBytes;
  logic [LANES-1:0] txnMask;
  logic done;

  always #2 clk = ~clk;

  hwc_coalescer #(.LANES(LANES), .AW(AW)) u_hwc_coalescer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqActive(reqActive), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqStrict(reqStrict), .txnValid(txnValid), .txnReady(txnReady),
    .txnBase(txnBase), .txnBytes(txnBytes), .txnMask(txnMask), .done(done)
  );

  int errCnt = 0;
  int chkCnt = 0;

  logic [AW-1:0]    laneAddr [LANES];
  logic [LANES-1:0] grpActive;
  int unsigned      expBase  [LANES];
  int unsigned      expBytes [LANES];
  logic [LANES-1:0] expMask  [LANES];
  int               expN;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic buildModel(input logic [LANES-1:0] act, input int size, input bit strict);
    int unsigned seg, esz, fb, sb, base, bytes, half;
    logic [LANES-1:0] pend, m;
    bit serial, hi, lo;
    int lead, first;
    esz  = 1 << size;
    seg  = (size == 0) ? 32 : (size == 1) ? 64 : 128;
    pend = act;
    expN = 0;
    serial = 1'b0;
    if (strict && act != '0) begin
      first = 0;
      while (!act[first]) first++;
      fb = (laneAddr[first] / seg) * seg;
      for (int k = 0; k < LANES; k++)
        if (act[k] && laneAddr[k] != fb + k * esz) serial = 1'b1;
    end
    while (pend != '0) begin
      lead = 0;
      while (!pend[lead]) lead++;
      sb = (laneAddr[lead] / seg) * seg;
      m  = '0;
      for (int k = 0; k < LANES; k++)
        if (pend[k] && (serial ? (k == lead) : ((laneAddr[k] / seg) * seg == sb)))
          m[k] = 1'b1;
      base = sb;
      bytes = seg;
      while (bytes > 32) begin
        half = bytes / 2;
        hi = 1'b0;
        lo = 1'b0;
        for (int k = 0; k < LANES; k++)
          if (m[k]) begin
            if (laneAddr[k] - base >= half) hi = 1'b1; else lo = 1'b1;
          end
        if (hi && lo) break;
        if (hi) base = base + half;
        bytes = half;
      end
      expBase[expN]  = base;
      expBytes[expN] = bytes;
      expMask[expN]  = m;
      expN++;
      pend = pend & ~m;
    end
  endtask

  // drive a group at the current negedge and let it be taken
  task automatic startGroup(input string req, input logic [LANES-1:0] act,
                            input int size, input bit strict, input bit junkWhileBusy);
    grpActive = act;
    for (int k = 0; k < LANES; k++) reqAddr[k*AW +: AW] = laneAddr[k];
    reqActive = act;
    reqSize   = 2'(size);
    reqStrict = strict;
    reqValid  = 1'b1;
    chk(reqReady == 1'b1, "R11", {req, " idle before group"}, reqReady, 1);
    buildModel(act, size, strict);
    @(posedge clk);
    @(negedge clk);
    if (junkWhileBusy) begin
      reqActive = ~act;
      reqAddr   = '1;
      reqSize   = 2'd0;
    end else begin
      reqValid = 1'b0;
    end
  endtask

  // collect and judge the transactions; ends at the negedge that shows done
  task automatic drainGroup(input string req, input bit stall);
    int idx = 0;
    int cyc = 0;
    logic [LANES-1:0] seen = '0;
    bit dup = 1'b0;
    bit held = 1'b0;
    logic [AW-1:0] hBase;
    logic [7:0] hBytes;
    logic [LANES-1:0] hMask;
    if (expN == 0) begin
      chk(done == 1'b1, "R12", {req, " done after empty group"}, done, 1);
      chk(txnValid == 1'b0, "R12", {req, " no transaction"}, txnValid, 0);
      return;
    end
    while (idx < expN && cyc < 200) begin
      txnReady = !(stall && (cyc % 3 == 1));
      chk(txnValid == 1'b1, "R7", {req, " transaction offered"}, txnValid, 1);
      chk(done == 1'b0 && reqReady == 1'b0, "R11", {req, " busy flags"},
          {done, reqReady}, 0);
      if (held) begin
        chk(txnBase == hBase && txnBytes == hBytes && txnMask == hMask, "R10",
            {req, " stalled mask held"}, txnMask, hMask);
        held = 1'b0;
      end
      if (txnValid && txnReady) begin
        chk(txnBase == expBase[idx], req, "base", txnBase, expBase[idx]);
        chk(txnBytes == expBytes[idx], req, "length", txnBytes, expBytes[idx]);
        chk(txnMask == expMask[idx], req, "mask", txnMask, expMask[idx]);
        for (int k = 0; k < LANES; k++)
          if (txnMask[k]) begin
            chk(laneAddr[k] >= txnBase && laneAddr[k] < txnBase + AW'(txnBytes), "R6",
                {req, " lane inside span"}, laneAddr[k], txnBase);
          end
        chk((txnBase % txnBytes) == 0, "R6", {req, " base aligned"}, txnBase, txnBytes);
        if ((seen & txnMask) != '0) dup = 1'b1;
        seen = seen | txnMask;
        idx++;
      end else if (txnValid) begin
        held = 1'b1;
        hBase = txnBase;
        hBytes = txnBytes;
        hMask = txnMask;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    chk(seen == grpActive && !dup, "R7", {req, " union of masks"}, seen, grpActive);
    chk(done == 1'b1, "R11", {req, " done after last"}, done, 1);
    chk(txnValid == 1'b0, "R11", {req, " idle after last"}, txnValid, 0);
  endtask

  task automatic fillConsec(input int unsigned base, input int size);
    for (int k = 0; k < LANES; k++) laneAddr[k] = AW'(base + (k << size));
  endtask

  task automatic testReset();
    chk(txnValid == 1'b0, "R1", "txnValid after reset", txnValid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
  endtask

  task automatic testSizes();
    fillConsec(32'h1000, 2);                 // 4-byte, 64 bytes used -> R3 R5
    startGroup("R3", '1, 2, 1'b0, 1'b0); drainGroup("R3", 1'b0);
    fillConsec(32'h2000, 3);                 // 8-byte, full 128 -> R4
    startGroup("R4", '1, 3, 1'b0, 1'b0); drainGroup("R4", 1'b0);
    fillConsec(32'h8003, 0);                 // 1-byte in 32-byte segment
    startGroup("R3", '1, 0, 1'b0, 1'b0); drainGroup("R3", 1'b0);
    fillConsec(32'h9020, 1);                 // 2-byte, upper 32 of a 64
    startGroup("R5", '1, 1, 1'b0, 1'b0); drainGroup("R5", 1'b0);
  endtask

  task automatic testUpperHalf();
    for (int k = 0; k < LANES; k++) laneAddr[k] = AW'(32'h7040 + 4 * (15 - k));
    startGroup("R5", '1, 2, 1'b0, 1'b0); drainGroup("R5", 1'b0);
  endtask

  task automatic fillScatter();
    for (int k = 0; k < LANES; k++) begin
      if (k < 5)       laneAddr[k] = AW'(32'h4000 + 4 * k);
      else if (k < 10) laneAddr[k] = AW'(32'h4080 + 4 * k);
      else             laneAddr[k] = AW'(32'h4040 + 4 * k);
    end
  endtask

  task automatic testScatter();
    fillScatter();
    startGroup("R2", 16'hF3DB, 2, 1'b0, 1'b0); drainGroup("R2", 1'b0);
  endtask

  task automatic testStallAndBusy();
    fillScatter();
    startGroup("R10", 16'hFFFF, 2, 1'b0, 1'b1); drainGroup("R10", 1'b1);
    reqValid = 1'b0;
  endtask

  task automatic testStrict();
    fillConsec(32'h5000, 2);
    startGroup("R8", '1, 2, 1'b1, 1'b0); drainGroup("R8", 1'b0);
    startGroup("R8", 16'h0F0E, 2, 1'b1, 1'b0); drainGroup("R8", 1'b0);
    laneAddr[2] = 32'h500C;
    laneAddr[3] = 32'h5008;
    startGroup("R9", '1, 2, 1'b1, 1'b0); drainGroup("R9", 1'b0);
    startGroup("R4", '1, 2, 1'b0, 1'b0); drainGroup("R4", 1'b0);
  endtask

  task automatic testEmpty();
    fillConsec(32'h6000, 2);
    startGroup("R12", '0, 2, 1'b0, 1'b0); drainGroup("R12", 1'b0);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < LANES; k++) laneAddr[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSizes();
    testUpperHalf();
    testScatter();
    testStrict();
    testEmpty();
    testStallAndBusy();
    @(negedge clk);
    chk(done == 1'b0, "R11", "done is a single pulse", done, 0);
    summary();
    $finish;
  end
endmodule